// File: doc/BRIEF.md
# Program/Erase Completion Status Generator

This block sits on the read path of a nonvolatile array controller and decides what a read returns while the array is busy with an internal program or erase operation. While the internal timer's busy flag is high, normal array data is replaced with a status byte. That byte carries two completion indicators at the same time. The first is a polarity bit that reads as the inverse of the matching bit of the byte last loaded for programming. The second is a toggle bit that flips on every read access.

A host polls by reading any location until the polarity bit matches its own data, or until two reads in a row show the same toggle bit. When busy drops, the output switches back to the live array data in the same cycle. No extra read or wait is needed before the next access.

The block keeps the last byte loaded and the toggle flip-flop. It detects read accesses from the rising edge of a read strobe. It does not time the operation itself.

Top module: `poll_status_gen`

## Requirements
- R1: While busy and the operation is a program (`op_erase_i`=0), output bit 7 equals the inverse of bit 7 of the last byte loaded through `load_we_i`/`load_byte_i`.
- R2: While busy, output bit 6 takes the opposite value on each successive read access, where a read access begins at a rising edge of `rd_strobe_i`. The new value appears in the cycle after that edge.
- R3: While `busy_i` is low, the output equals `array_byte_i` on all eight bits, in the same cycle, including the cycle in which busy falls.
- R4: A read strobe held high for several cycles advances the toggle bit only once. Between rising edges, bit 6 holds its value.
- R5: Read accesses while not busy do not advance the toggle bit. Bit 6 at the next busy period continues from its last busy value.
- R6: While busy and the operation is an erase (`op_erase_i`=1), output bit 7 reads 0.
- R7: While busy, output bits 5 down to 0 read 0 whatever the array data is.
- R8: Status replaces array data in the first cycle in which busy is high, without waiting for a read edge.
- R9: A newer load replaces the held byte, so the polarity bit follows the most recent load.
- R10: After reset the held byte is 0x00 and the toggle bit is 0. A busy program read before any load therefore returns 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | High while the internal program/erase timer runs |
| op_erase_i | input | 1 | 1 = erase in progress, 0 = program in progress |
| load_we_i | input | 1 | Captures `load_byte_i` as the byte being programmed |
| load_byte_i | input | 8 | Data byte loaded for programming |
| rd_strobe_i | input | 1 | Read access strobe; a rising edge starts one access |
| array_byte_i | input | 8 | Data read from the array |
| rd_byte_o | output | 8 | Read data returned to the host |

## Verification
The assertions assume that `op_erase_i` describes the running operation for the whole busy period. They also assume that a read access is marked by a single rising edge of `rd_strobe_i`, however long the strobe then stays high. The stimulus changes the operation type only while busy is low. It issues reads as one-cycle pulses, as strobes held for many cycles, and as back-to-back edges. Loads are applied while idle, and in a few cycles together with busy, to show that the polarity bit tracks the most recent load.

// File: rtl/poll_pkg.sv
package poll_pkg;

   typedef enum logic {
      OPK_PROGRAM = 1'b0,
      OPK_ERASE   = 1'b1
   } op_kind_e;

   // Builds the status word: polarity bit, toggle bit, all other bits clear.
   function automatic logic [63:0] make_status
      (input int unsigned width,
       input int unsigned pol_pos,
       input int unsigned tog_pos,
       input op_kind_e    kind,
       input logic        held_bit,
       input logic        tog);
      logic [63:0] w;
      w = '0;
      w[pol_pos] = (kind == OPK_ERASE) ? 1'b0 : ~held_bit;
      w[tog_pos] = tog;
      for (int unsigned i = width; i < 64; i++) w[i] = 1'b0;
      return w;
   endfunction

endpackage

// File: rtl/poll_read_edge.sv
module poll_read_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic rise_o
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe_i;
   end

   assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/poll_toggle_cell.sv
module poll_toggle_cell #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance_i,
   output logic tog_o
);
   logic tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         tog_q <= RESET_VAL;
      else if (advance_i) tog_q <= ~tog_q;
   end

   assign tog_o = tog_q;
endmodule

// File: rtl/poll_load_hold.sv
module poll_load_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [DATA_W-1:0] held_o
);
   logic [DATA_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    held_q <= '0;
      else if (we_i) held_q <= byte_i;
   end

   assign held_o = held_q;
endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux
   import poll_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TOGGLE_BIT = 6,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  op_kind_e          kind_i,
   input  logic              held_bit_i,
   input  logic              tog_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] data_o
);
   logic [63:0]       status_w;
   logic [DATA_W-1:0] next_data;

   always_comb begin
      status_w  = make_status(DATA_W, POLL_BIT, TOGGLE_BIT, kind_i, held_bit_i, tog_i);
      next_data = busy_i ? status_w[DATA_W-1:0] : array_i;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n) data_q <= '0;
            else        data_q <= next_data;
         end
         assign data_o = data_q;
      end else begin : g_comb
         assign data_o = next_data;
      end
   endgenerate
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
   import poll_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned POLL_BIT    = 7,
   parameter int unsigned TOGGLE_BIT  = 6,
   parameter bit          OUT_REG     = 1'b0,
   parameter bit          TOGGLE_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_erase_i,
   input  logic              load_we_i,
   input  logic [DATA_W-1:0] load_byte_i,
   input  logic              rd_strobe_i,
   input  logic [DATA_W-1:0] array_byte_i,
   output logic [DATA_W-1:0] rd_byte_o
);
   localparam int unsigned MAX_W = 64;

   generate
      if (DATA_W < 2 || DATA_W > MAX_W) begin : g_bad_width
         $error("poll_status_gen: DATA_W out of range");
      end
      if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W) begin : g_bad_pos
         $error("poll_status_gen: status bit position outside data word");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_overlap
         $error("poll_status_gen: polarity and toggle bits must differ");
      end
   endgenerate

   logic              read_rise;
   logic              tog;
   logic [DATA_W-1:0] held;
   op_kind_e          kind;

   assign kind = op_erase_i ? OPK_ERASE : OPK_PROGRAM;

   poll_read_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (rd_strobe_i),
      .rise_o   (read_rise)
   );

   poll_toggle_cell #(.RESET_VAL(TOGGLE_INIT)) u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (read_rise & busy_i),
      .tog_o     (tog)
   );

   poll_load_hold #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (load_we_i),
      .byte_i (load_byte_i),
      .held_o (held)
   );

   poll_status_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT),
      .OUT_REG    (OUT_REG)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_i),
      .kind_i     (kind),
      .held_bit_i (held[POLL_BIT]),
      .tog_i      (tog),
      .array_i    (array_byte_i),
      .data_o     (rd_byte_o)
   );
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TOGGLE_BIT = 6,
   parameter bit          OUT_REG    = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              op_erase_i,
   input logic              load_we_i,
   input logic [DATA_W-1:0] load_byte_i,
   input logic              rd_strobe_i,
   input logic [DATA_W-1:0] array_byte_i,
   input logic [DATA_W-1:0] rd_byte_o
);
   localparam logic [DATA_W-1:0] FLAG_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

   logic              strobe_seen;
   logic [DATA_W-1:0] shadow_load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_seen <= 1'b0;
         shadow_load <= '0;
      end else begin
         strobe_seen <= rd_strobe_i;
         if (load_we_i) shadow_load <= load_byte_i;
      end
   end

   generate
      if (!OUT_REG) begin : g_comb_chk
         // R1
         program_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && !op_erase_i) |-> rd_byte_o[POLL_BIT] == ~shadow_load[POLL_BIT]);

         // R2
         toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && rd_strobe_i && !strobe_seen) |=>
               (!busy_i || rd_byte_o[TOGGLE_BIT] != $past(rd_byte_o[TOGGLE_BIT])));

         // R3
         idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_i |-> rd_byte_o == array_byte_i);

         // R4
         toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && !(rd_strobe_i && !strobe_seen)) |=>
               (!busy_i || $stable(rd_byte_o[TOGGLE_BIT])));

         // R6
         erase_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && op_erase_i) |-> rd_byte_o[POLL_BIT] == 1'b0);

         // R7
         quiet_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy_i |-> (rd_byte_o & ~FLAG_MASK) == '0);
      end
   endgenerate
endmodule

bind poll_status_gen poll_status_chk #(
   .DATA_W     (DATA_W),
   .POLL_BIT   (POLL_BIT),
   .TOGGLE_BIT (TOGGLE_BIT),
   .OUT_REG    (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_i       (busy_i),
   .op_erase_i   (op_erase_i),
   .load_we_i    (load_we_i),
   .load_byte_i  (load_byte_i),
   .rd_strobe_i  (rd_strobe_i),
   .array_byte_i (array_byte_i),
   .rd_byte_o    (rd_byte_o)
);

// File: tb/sim_poll_status_gen.sv
`timescale 1ns/1ps
module sim_poll_status_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy = 1'b0;
   logic       erase = 1'b0;
   logic       lwe = 1'b0;
   logic [7:0] lbyte = 8'h00;
   logic       rd = 1'b0;
   logic [7:0] arr = 8'h00;
   logic [7:0] dout;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural reference state
   int unsigned m_last = 0;
   int unsigned m_tog  = 0;
   bit          m_rd_prev = 1'b0;

   always #2.5 clk = ~clk;

   poll_status_gen u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy_i       (busy),
      .op_erase_i   (erase),
      .load_we_i    (lwe),
      .load_byte_i  (lbyte),
      .rd_strobe_i  (rd),
      .array_byte_i (arr),
      .rd_byte_o    (dout)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_last = 0; m_tog = 0; m_rd_prev = 1'b0;
      end else begin
         if (lwe) m_last = int'(lbyte);
         if (busy && rd && !m_rd_prev) m_tog = 1 - m_tog;
         m_rd_prev = rd;
      end
   end

   function automatic int unsigned expect_out();
      int unsigned v;
      if (!busy) return int'(arr);
      v = 0;
      if (!erase && ((m_last / 128) % 2 == 0)) v += 128;
      if (m_tog == 1) v += 64;
      return v;
   endfunction

   task automatic check(input string tag);
      int unsigned e;
      e = expect_out();
      checks++;
      if (int'(dout) != e) begin
         errors++;
         $display("FAIL %s: rd_byte actual=%02h expected=%02h", tag, dout, e[7:0]);
      end
   endtask

   task automatic step(input bit b, input bit e, input bit lw, input logic [7:0] lb,
                       input bit r, input logic [7:0] a, input string tag);
      @(negedge clk);
      busy = b; erase = e; lwe = lw; lbyte = lb; rd = r; arr = a;
      #1;
      check(tag);
   endtask

   initial begin
      #(200000.0 * 5.0);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state, busy program read before any load gives 0x80
      step(0, 0, 0, 8'h00, 0, 8'h3C, "R10");
      step(1, 0, 0, 8'h00, 0, 8'hFF, "R10");
      step(0, 0, 0, 8'h00, 0, 8'hA5, "R3");
      // R3: idle passthrough under several patterns, strobes present
      step(0, 0, 0, 8'h00, 1, 8'h00, "R3");
      step(0, 0, 0, 8'h00, 0, 8'hFF, "R3");
      step(0, 0, 0, 8'h00, 1, 8'h69, "R5");
      step(0, 0, 0, 8'h00, 0, 8'h96, "R5");
      // R1/R2: program with loaded byte bit7=0
      step(0, 0, 1, 8'h5A, 0, 8'h11, "R9");
      step(1, 0, 0, 8'h00, 1, 8'h5A, "R8");
      for (int i = 0; i < 8; i++) begin
         step(1, 0, 0, 8'h00, 0, 8'h5A, "R2");
         step(1, 0, 0, 8'h00, 1, 8'hC3, "R1");
      end
      step(1, 0, 0, 8'h00, 0, 8'h7E, "R7");
      // R3: true data in the cycle busy falls
      step(0, 0, 0, 8'h00, 0, 8'h5A, "R3");
      // R4: strobe held high for many cycles, one advance only
      step(0, 0, 1, 8'hC3, 0, 8'h00, "R9");
      step(1, 0, 0, 8'h00, 1, 8'h3F, "R4");
      for (int i = 0; i < 6; i++) step(1, 0, 0, 8'h00, 1, 8'h3F, "R4");
      step(1, 0, 0, 8'h00, 0, 8'h3F, "R4");
      step(1, 0, 0, 8'h00, 0, 8'h3F, "R4");
      // R5: idle reads do not move the toggle
      step(0, 0, 0, 8'h00, 0, 8'h01, "R5");
      for (int i = 0; i < 5; i++) begin
         step(0, 0, 0, 8'h00, 1, 8'h02, "R5");
         step(0, 0, 0, 8'h00, 0, 8'h04, "R5");
      end
      step(1, 0, 0, 8'h00, 0, 8'h08, "R5");
      // R6: erase reads bit7 as 0, toggle still active
      step(0, 1, 0, 8'h00, 0, 8'hFF, "R3");
      for (int i = 0; i < 6; i++) begin
         step(1, 1, 0, 8'h00, 1, 8'hFF, "R6");
         step(1, 1, 0, 8'h00, 0, 8'hFF, "R6");
      end
      step(0, 1, 0, 8'h00, 0, 8'hFF, "R3");
      // R9: load during busy takes effect next cycle
      step(0, 0, 0, 8'h00, 0, 8'h00, "R3");
      step(1, 0, 1, 8'h80, 1, 8'h00, "R9");
      step(1, 0, 0, 8'h00, 0, 8'h00, "R9");
      step(1, 0, 1, 8'h00, 1, 8'h00, "R9");
      step(1, 0, 0, 8'h00, 0, 8'h00, "R9");
      step(0, 0, 0, 8'h00, 0, 8'h00, "R3");
      // mixed traffic, operation type fixed per busy period
      for (int blk = 0; blk < 40; blk++) begin
         bit ek;
         ek = ($urandom % 3) == 0;
         step(0, ek, 1, 8'($urandom), $urandom % 2, 8'($urandom), "R3");
         for (int c = 0; c < 1 + $urandom % 12; c++)
            step(1, ek, 1'b0, 8'h00, $urandom % 2, 8'($urandom), ek ? "R6" : "R1");
         step(0, ek, 0, 8'h00, $urandom % 2, 8'($urandom), "R3");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule